// File: doc/BRIEF.md
# Block-Addressed SPI Register Master

This block carries out single 32-bit register reads and writes over an SPI link (mode 0) on a device whose registers are reached through a 3-bit block number, a 4-bit subblock number and an 8-bit register address. The user side presents one request at a time: a direction, the block, subblock and address, and the write word. The block then runs one complete chip-select frame. It returns the read word, a one-cycle completion strobe and an error flag.

Each frame opens with a command byte that packs block, direction and subblock together. The register address byte comes next. A write then sends the data word. A read first sends a configurable number of zero filler bytes and then clocks in the reply word. Before any frame starts, the block/subblock pair is checked against a fixed table of legal pairs. An illegal pair is refused at once and the serial pins do not move.

Top module: `blkreg_spi_master`

## Requirements
- R1: The first byte of every frame is {block[2:0], dir, subblock[3:0]}, with dir = 1 for a write and 0 for a read. All bytes go out most significant bit first.
- R2: The second byte of every frame is the 8-bit register address.
- R3: A write follows the address with the 32-bit data word, most significant byte first. The frame is exactly 48 SCLK cycles long.
- R4: A read follows the address with `pad_cnt` zero bytes (0 to 3, where 0 means none). It then samples 32 MISO bits, MSB first, into `rd_data`. The frame is 48 + 8*pad_cnt SCLK cycles long.
- R5: `rd_data` is updated only when a read frame completes. A write leaves it unchanged.
- R6: The legal pairs are: block 1 with subblocks 0-4 and 6; blocks 2 and 7 with subblock 0; blocks 3, 4 and 5 with subblocks 0 and 1. A request with any other pair raises `done` and `err` together in the cycle after the request. `cs_n` stays high and SCLK does not toggle.
- R7: SPI mode 0. SCLK idles low and is high only while `cs_n` is low. MOSI changes only on falling SCLK edges and stays stable while SCLK is high. MISO is sampled on rising edges.
- R8: The SCLK high phase and low phase each last DIV_HALF system clock cycles. The first rising edge comes DIV_HALF cycles after `cs_n` falls.
- R9: `done` is high for a single cycle, and for a legal access that cycle is the one in which `cs_n` returns high. `busy` is high from acceptance until that point.
- R10: A request presented while `busy` is high is ignored. It does not change the running frame and does not start another frame.
- R11: After reset, `cs_n`=1, `sclk`=0, `done`=0, `err`=0, `busy`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken only while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_blk | input | 3 | Target block |
| req_sub | input | 4 | Target subblock |
| req_addr | input | 8 | Register address |
| req_wdata | input | 32 | Write word |
| pad_cnt | input | 2 | Zero bytes sent before read data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request refused (illegal pair), valid with done |
| rd_data | output | 32 | Word from the latest completed read |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The hardest situation to reach from the ports is a second request that arrives in the middle of a frame. It must leave both the bits on the wire and the frame count untouched. The bench starts a write, presents a different, legal read while `busy` is high, and compares every captured MOSI bit against the first request only. During header and filler bits the device model drives MISO high, so a read that keeps any bit outside the last 32 shows up as a wrong word.

// File: rtl/blkreg_spi_pkg.sv
package blkreg_spi_pkg;
  localparam int BLK_W    = 3;
  localparam int SUB_W    = 4;
  localparam int ADDR_W   = 8;
  localparam int WORD_W   = 32;
  localparam int PAD_W    = 2;
  localparam int HDR_BITS = BLK_W + 1 + SUB_W + ADDR_W;
  localparam int PAD_MAX  = (1 << PAD_W) - 1;
  localparam int FRAME_MAX = HDR_BITS + 8 * PAD_MAX + WORD_W;
  localparam int CNT_W    = $clog2(FRAME_MAX + 1);

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_HIGH,
    SEQ_LOW,
    SEQ_TRAIL
  } seq_state_t;

  function automatic logic [7:0] pack_cmd(input logic [BLK_W-1:0] blk,
                                          input logic wr,
                                          input logic [SUB_W-1:0] sub);
    return {blk, wr, sub};
  endfunction
endpackage

// File: rtl/blkreg_map_check.sv
module blkreg_map_check
  import blkreg_spi_pkg::*;
(
  input  logic [BLK_W-1:0] blk,
  input  logic [SUB_W-1:0] sub,
  output logic             legal
);
  always_comb begin
    case (blk)
      3'd1:             legal = (sub <= 4'd4) || (sub == 4'd6);
      3'd2, 3'd7:       legal = (sub == 4'd0);
      3'd3, 3'd4, 3'd5: legal = (sub <= 4'd1);
      default:          legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/blkreg_phase_timer.sv
module blkreg_phase_timer #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV_HALF <= 1) begin : g_direct
      logic unused_in;
      assign unused_in = clk ^ rst;
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)    cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/blkreg_frame_shift.sv
module blkreg_frame_shift #(
  parameter int FRAME_BITS = 72,
  parameter int RX_W       = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_val,
  input  logic                  shift,
  input  logic                  sample,
  input  logic                  ser_in,
  output logic                  ser_out,
  output logic [RX_W-1:0]       rx_word
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [RX_W-1:0]       rx_q;

  always_ff @(posedge clk) begin
    if (rst)        tx_q <= '0;
    else if (load)  tx_q <= load_val;
    else if (shift) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || load) rx_q <= '0;
    else if (sample) rx_q <= {rx_q[RX_W-2:0], ser_in};
  end

  assign ser_out = tx_q[FRAME_BITS-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/blkreg_spi_master.sv
module blkreg_spi_master
  import blkreg_spi_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [PAD_W-1:0]  pad_cnt,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rd_data,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int TAIL_W = FRAME_MAX - HDR_BITS - WORD_W;
  localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(HDR_BITS + WORD_W);

  seq_state_t         state_q;
  logic [CNT_W-1:0]   bits_left_q;
  logic               is_rd_q;
  logic               cs_q, sclk_q, done_q, err_q;
  logic [WORD_W-1:0]  rd_q;

  logic               legal;
  logic               tick;
  logic               load, shift, sample;
  logic [FRAME_MAX-1:0] frame_img;
  logic [CNT_W-1:0]   frame_len;
  logic [WORD_W-1:0]  rx_word;
  logic               ser_out;

  blkreg_map_check u_map (
    .blk   (req_blk),
    .sub   (req_sub),
    .legal (legal)
  );

  blkreg_phase_timer #(.DIV_HALF(DIV_HALF)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q != SEQ_IDLE),
    .tick (tick)
  );

  always_comb begin
    if (req_wr)
      frame_img = {pack_cmd(req_blk, 1'b1, req_sub), req_addr, req_wdata, {TAIL_W{1'b0}}};
    else
      frame_img = {pack_cmd(req_blk, 1'b0, req_sub), req_addr, {(FRAME_MAX-HDR_BITS){1'b0}}};
    frame_len = req_wr ? BASE_LEN : BASE_LEN + CNT_W'({pad_cnt, 3'b000});
  end

  assign load   = (state_q == SEQ_IDLE) && req && legal;
  assign sample = tick && ((state_q == SEQ_LEAD) || (state_q == SEQ_LOW));
  assign shift  = tick && (state_q == SEQ_HIGH) && (bits_left_q != CNT_W'(1));

  blkreg_frame_shift #(.FRAME_BITS(FRAME_MAX), .RX_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (frame_img),
    .shift    (shift),
    .sample   (sample),
    .ser_in   (miso),
    .ser_out  (ser_out),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      bits_left_q <= '0;
      is_rd_q     <= 1'b0;
      cs_q        <= 1'b1;
      sclk_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      rd_q        <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (req) begin
            if (legal) begin
              cs_q        <= 1'b0;
              is_rd_q     <= !req_wr;
              bits_left_q <= frame_len;
              state_q     <= SEQ_LEAD;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        SEQ_LEAD, SEQ_LOW: begin
          if (tick) begin
            sclk_q  <= 1'b1;
            state_q <= SEQ_HIGH;
          end
        end
        SEQ_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (bits_left_q == CNT_W'(1)) begin
              state_q <= SEQ_TRAIL;
            end else begin
              bits_left_q <= bits_left_q - 1'b1;
              state_q     <= SEQ_LOW;
            end
          end
        end
        SEQ_TRAIL: begin
          if (tick) begin
            cs_q    <= 1'b1;
            done_q  <= 1'b1;
            state_q <= SEQ_IDLE;
            if (is_rd_q) rd_q <= rx_word;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != SEQ_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rd_q;
  assign cs_n    = cs_q;
  assign sclk    = sclk_q;
  assign mosi    = ser_out;
endmodule

// File: rtl/blkreg_spi_chk.sv
module blkreg_spi_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  // R7: serial clock only pulses inside a frame
  assert_sclk_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R7: MOSI holds while SCLK is high
  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  // R9: chip select release coincides with done and end of busy
  assert_release_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (done && !busy));

  // R6: error is only reported together with done
  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R9: chip select low only while busy
  assert_cs_only_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R6: an erroring request never opens a frame
  assert_err_no_frame_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && !sclk));
endmodule

bind blkreg_spi_master blkreg_spi_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .busy (busy),
  .done (done),
  .err  (err),
  .cs_n (cs_n),
  .sclk (sclk),
  .mosi (mosi)
);

// File: tb/sim_blkreg_spi_master.sv
`timescale 1ns/1ps
module sim_blkreg_spi_master;
  localparam int DIV = 2;
  localparam int NV  = 12;
  // {wr, blk[2:0], sub[3:0], addr[7:0], data[31:0], pad[1:0], bad}
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 3'd1, 4'd0, 8'h00, 32'hA5C3_0F12, 2'd2, 1'b0},
    {1'b0, 3'd7, 4'd0, 8'h18, 32'h7385_1234, 2'd2, 1'b0},
    {1'b0, 3'd3, 4'd1, 8'h50, 32'hDEAD_BEEF, 2'd0, 1'b0},
    {1'b1, 3'd5, 4'd1, 8'hFF, 32'h8000_0001, 2'd3, 1'b0},
    {1'b0, 3'd1, 4'd6, 8'h19, 32'h0F0F_5AA5, 2'd1, 1'b0},
    {1'b1, 3'd1, 4'd5, 8'h10, 32'h1111_1111, 2'd2, 1'b1},
    {1'b0, 3'd2, 4'd1, 8'h20, 32'h2222_2222, 2'd2, 1'b1},
    {1'b1, 3'd0, 4'd0, 8'h30, 32'h3333_3333, 2'd2, 1'b1},
    {1'b0, 3'd6, 4'd0, 8'h40, 32'h4444_4444, 2'd2, 1'b1},
    {1'b1, 3'd4, 4'd0, 8'h3C, 32'hFFFF_FFFF, 2'd2, 1'b0},
    {1'b0, 3'd1, 4'd4, 8'h01, 32'h0000_0000, 2'd3, 1'b0},
    {1'b0, 3'd7, 4'd15, 8'h55, 32'h5555_5555, 2'd0, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic req = 0, req_wr = 0;
  logic [2:0] req_blk = 0;
  logic [3:0] req_sub = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [1:0] pad_cnt = 0;
  logic busy, done, err, cs_n, sclk, mosi, miso;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;

  // device model state
  int cur_n = 48;
  logic [31:0] cur_rd = '0;
  int fall_total = 0, fall_base = 0, rise_total = 0, rise_base = 0;
  int frames = 0, stray = 0;
  logic [71:0] cap = '0;
  time t_csfall = 0, t_rise = 0, t_fall = 0, lead_len = 0, hi_len = 0, lo_len = 0;

  always #5 clk = ~clk;

  blkreg_spi_master #(.DIV_HALF(DIV)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_blk(req_blk),
    .req_sub(req_sub), .req_addr(req_addr), .req_wdata(req_wdata),
    .pad_cnt(pad_cnt), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic dev_bit(input int i, input int n, input logic [31:0] w);
    if (i >= n - 32 && i < n) return w[n - 1 - i];
    return 1'b1;
  endfunction

  assign miso = dev_bit(fall_total - fall_base, cur_n, cur_rd);

  always @(negedge cs_n) begin
    fall_base = fall_total;
    rise_base = rise_total;
    t_csfall  = $time;
    frames++;
  end

  always @(posedge sclk) begin
    if (cs_n) stray++;
    if (rise_total == rise_base) lead_len = $time - t_csfall;
    else lo_len = $time - t_fall;
    cap = {cap[70:0], mosi};
    rise_total++;
    t_rise = $time;
  end

  always @(negedge sclk) begin
    hi_len = $time - t_rise;
    t_fall = $time;
    fall_total++;
  end

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic drive_req(input logic wr, input logic [2:0] b, input logic [3:0] s,
                           input logic [7:0] a, input logic [31:0] d, input logic [1:0] p);
    @(negedge clk);
    req = 1; req_wr = wr; req_blk = b; req_sub = s; req_addr = a; req_wdata = d; pad_cnt = p;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  task automatic access(input logic wr, input logic [2:0] b, input logic [3:0] s,
                        input logic [7:0] a, input logic [31:0] d, input logic [1:0] p,
                        input logic bad);
    int f0, r0, n, nbits;
    logic [71:0] al;
    logic [31:0] rd_before;
    bit ok;
    n = wr ? 48 : 48 + 8 * p;
    cur_n = n;
    cur_rd = wr ? 32'h0 : d;
    f0 = frames; r0 = rise_total;
    rd_before = rd_data;
    drive_req(wr, b, s, a, d, p);
    if (bad) begin
      check(done === 1'b1 && err === 1'b1, "R6 reject strobe", {70'd0, done, err}, 72'd3);
      repeat (6 * DIV) @(negedge clk);
      check(frames == f0 && rise_total == r0 && cs_n === 1'b1, "R6 no line activity",
            72'(frames - f0 + rise_total - r0), 72'd0);
      check(rd_data === rd_before, "R5 rd_data kept on reject", 72'(rd_data), 72'(rd_before));
      return;
    end
    wait_done(ok);
    check(ok && err === 1'b0 && cs_n === 1'b1 && !busy, "R9 done at release", {69'd0, ok, err, cs_n}, 72'd5);
    nbits = rise_total - r0;
    check(frames == f0 + 1, "R7 one chip-select frame", 72'(frames - f0), 72'd1);
    check(nbits == n, wr ? "R3 write frame length" : "R4 read frame length", 72'(nbits), 72'(n));
    al = cap << (72 - n);
    check(al[71:64] == {b, wr, s}, "R1 command byte", 72'(al[71:64]), 72'({b, wr, s}));
    check(al[63:56] == a, "R2 address byte", 72'(al[63:56]), 72'(a));
    if (wr) begin
      check(al[55:24] == d, "R3 write data", 72'(al[55:24]), 72'(d));
      check(rd_data === rd_before, "R5 write keeps rd_data", 72'(rd_data), 72'(rd_before));
    end else begin
      logic [71:0] padmask;
      padmask = ({72{1'b1}} << (72 - 8 * int'(p))) >> 16;
      check((al & padmask) == 0, "R4 pad bytes zero", al & padmask, 72'd0);
      check(rd_data === d, "R4 read data", 72'(rd_data), 72'(d));
    end
    check(hi_len == DIV * 10 && lo_len == DIV * 10 && lead_len == DIV * 10, "R8 phase timing",
          72'(hi_len + lo_len + lead_len), 72'(3 * DIV * 10));
    @(negedge clk);
    check(done === 1'b0, "R9 done single cycle", 72'(done), 72'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    check(cs_n === 1 && sclk === 0 && done === 0 && err === 0 && busy === 0 && rd_data === 0,
          "R11 reset state", {66'd0, cs_n, sclk, done, err, busy, |rd_data}, 72'h20);
    rst = 0;
    repeat (2) @(negedge clk);
    check(stray == 0 && frames == 0, "R7 idle lines", 72'(stray + frames), 72'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][50], VEC[i][49:47], VEC[i][46:43], VEC[i][42:35], VEC[i][34:3],
             VEC[i][2:1], VEC[i][0]);
    end

    // R10: request while busy is ignored
    begin
      int f0;
      bit ok;
      logic [71:0] al;
      logic [31:0] rd_before;
      cur_n = 48; cur_rd = 32'h0;
      f0 = frames;
      rd_before = rd_data;
      drive_req(1'b1, 3'd3, 4'd0, 8'hA7, 32'h1234_5678, 2'd0);
      repeat (10) @(negedge clk);
      check(busy === 1'b1, "R9 busy during frame", 72'(busy), 72'd1);
      drive_req(1'b0, 3'd2, 4'd0, 8'h5E, 32'h0, 2'd3);
      wait_done(ok);
      al = cap << 24;
      check(ok && al[71:64] == 8'h70 && al[63:56] == 8'hA7 && al[55:24] == 32'h1234_5678,
            "R10 running frame unchanged", al, {8'h70, 8'hA7, 32'h1234_5678, 24'h0});
      repeat (30 * DIV) @(negedge clk);
      check(frames == f0 + 1 && cs_n === 1'b1 && !busy, "R10 no second frame",
            72'(frames - f0), 72'd1);
      check(rd_data === rd_before, "R10 rd_data unchanged", 72'(rd_data), 72'(rd_before));
    end

    summary();
    $finish;
  end
endmodule